// File: doc/BRIEF.md
# Clamped Digital Pulse-Width Modulator

This block drives the main switch of a switched-mode converter from a digital duty command. A free-running period counter of `RES_W` bits (1024 clocks per period by default) defines the switching period. The switching output rises at the start of every period and stays high for a number of clocks equal to the active duty word. This is trailing-edge modulation.

The duty command is a fraction of the period in `CMD_W` bits. The block truncates it to `RES_W` bits, so one LSB is 1/1024 of a period by default. It then clamps the result between a lower and an upper limit; the defaults are 0 and 819, which is 0.8 of the period. A valid command is first written to a shadow register and becomes active only when the counter wraps to the start of the next period. A change therefore never cuts into a pulse that is already running.

The block also emits a one-clock strobe in the first cycle of each period, the cycle in which the output rises. The control loop uses this strobe to start sampling its error signal.

Top module: `dpwm_clamped`

## Requirements
- R1: While reset is held, `pwm_out` and `period_start` are low. The first period after reset release runs with an active duty of zero, so `pwm_out` stays low for that whole period.
- R2: `period_start` is high for exactly one clock in every 2^RES_W clocks (1024 by default). The first strobe comes in the first clock after reset release.
- R3: When the active duty D is non-zero, `pwm_out` is high in the strobe cycle and in the following D-1 cycles, and low for the rest of the period. The output rises only in a strobe cycle.
- R4: The command is quantised by truncation: the duty in clocks is `duty_cmd >> (CMD_W-RES_W)`, which is bits [15:6] with the defaults. Examples: 0x8000 gives 512, 0x12FF gives 75 and 0x0041 gives 1.
- R5: A quantised duty above DUTY_MAX (819) is replaced by DUTY_MAX. Examples: 0xCD00 (820) and 0xFFFF (1023) both give 819 high clocks.
- R6: A quantised duty of zero keeps `pwm_out` low for the whole period. For example, 0x003F gives zero.
- R7: A command accepted during a period does not change that period. It takes effect from the next strobe.
- R8: A command accepted in the last clock of a period, the same cycle in which the counter wraps, takes effect in the period that starts on the next clock.
- R9: While `duty_cmd_valid` is low, `duty_cmd` is ignored and the last accepted duty stays active.
- R10: When several commands are accepted within one period, the last one sets the duty of the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| duty_cmd | input | CMD_W (16) | Duty command as a fraction of the period |
| duty_cmd_valid | input | 1 | Accept `duty_cmd` on this clock |
| pwm_out | output | 1 | Switching signal, trailing-edge modulated |
| period_start | output | 1 | One-clock strobe in the first cycle of each period |

## Verification
Loading a new command into the shadow register and transferring the shadow into the active duty can fall in the same clock. This happens when a command is accepted in the last cycle of a period, just as the counter wraps. The bench provokes it by raising `duty_cmd_valid` at exactly that cycle. It then requires the very next period to show the new high time, so a design that copies the stale shadow value is caught. The same run also places several commands inside one period and drives changing data while valid is low. Each following period is then measured clock by clock against the expected duty.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
    // Default geometry of the modulator
    localparam int RES_W_DEF    = 10;   // period counter / duty resolution
    localparam int CMD_W_DEF    = 16;   // width of the incoming command
    localparam int DUTY_MIN_DEF = 0;    // lowest duty in clocks
    localparam int DUTY_MAX_DEF = 819;  // highest duty in clocks (0.8 of 1024)
endpackage

// File: rtl/dpwm_cmd_shaper.sv
module dpwm_cmd_shaper #(
    parameter int CMD_W    = dpwm_pkg::CMD_W_DEF,
    parameter int RES_W    = dpwm_pkg::RES_W_DEF,
    parameter int DUTY_MIN = dpwm_pkg::DUTY_MIN_DEF,
    parameter int DUTY_MAX = dpwm_pkg::DUTY_MAX_DEF
) (
    input  logic [CMD_W-1:0] cmd,
    output logic [RES_W-1:0] duty
);
    localparam logic [RES_W-1:0] LIM_HI = RES_W'(DUTY_MAX);
    localparam logic [RES_W-1:0] LIM_LO = RES_W'(DUTY_MIN);

    logic [RES_W-1:0] raw;

    // Quantisation: keep the most significant RES_W bits of the command
    generate
        if (CMD_W >= RES_W) begin : g_trunc
            localparam int SHIFT = CMD_W - RES_W;
            assign raw = RES_W'(cmd >> SHIFT);
        end else begin : g_widen
            assign raw = {cmd, {(RES_W-CMD_W){1'b0}}};
        end
    endgenerate

    // Clamp into the allowed duty window
    generate
        if (DUTY_MIN > 0) begin : g_two_sided
            always_comb begin
                if (raw > LIM_HI)      duty = LIM_HI;
                else if (raw < LIM_LO) duty = LIM_LO;
                else                   duty = raw;
            end
        end else begin : g_upper_only
            always_comb begin
                if (raw > LIM_HI) duty = LIM_HI;
                else              duty = raw;
            end
        end
    endgenerate
endmodule

// File: rtl/dpwm_period_timer.sv
module dpwm_period_timer #(
    parameter int RES_W = dpwm_pkg::RES_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [RES_W-1:0] cnt_next,
    output logic             period_end
);
    localparam logic [RES_W-1:0] LAST = '1;

    typedef struct packed {
        logic [RES_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.cnt == LAST) tmr_d.cnt = '0;
        else                   tmr_d.cnt = tmr_q.cnt + 1'b1;
    end

    // Reset parks the counter on its last value so the first edge starts a period
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '{cnt: LAST};
        else        tmr_q <= tmr_d;
    end

    assign cnt_next   = tmr_d.cnt;
    assign period_end = (tmr_q.cnt == LAST);
endmodule

// File: rtl/dpwm_compare.sv
module dpwm_compare #(
    parameter int RES_W = dpwm_pkg::RES_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RES_W-1:0] cnt_next,
    input  logic             period_end,
    input  logic             load_en,
    input  logic [RES_W-1:0] load_duty,
    output logic             pwm,
    output logic             strobe,
    output logic [RES_W-1:0] act_duty
);
    typedef struct packed {
        logic [RES_W-1:0] shd;  // shadow duty, written by commands
        logic [RES_W-1:0] act;  // duty in force for the running period
        logic             pwm;
        logic             stb;
    } cmp_t;

    cmp_t cmp_d, cmp_q;

    always_comb begin
        cmp_d = cmp_q;
        if (load_en) cmp_d.shd = load_duty;
        // Transfer at the wrap sees a command arriving in the same cycle
        if (period_end) cmp_d.act = cmp_d.shd;
        cmp_d.pwm = (cnt_next < cmp_d.act);
        cmp_d.stb = period_end;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmp_q <= '{shd: '0, act: '0, pwm: 1'b0, stb: 1'b0};
        else        cmp_q <= cmp_d;
    end

    assign pwm      = cmp_q.pwm;
    assign strobe   = cmp_q.stb;
    assign act_duty = cmp_q.act;
endmodule

// File: rtl/dpwm_clamped.sv
module dpwm_clamped #(
    parameter int CMD_W    = dpwm_pkg::CMD_W_DEF,
    parameter int RES_W    = dpwm_pkg::RES_W_DEF,
    parameter int DUTY_MIN = dpwm_pkg::DUTY_MIN_DEF,
    parameter int DUTY_MAX = dpwm_pkg::DUTY_MAX_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CMD_W-1:0] duty_cmd,
    input  logic             duty_cmd_valid,
    output logic             pwm_out,
    output logic             period_start
);
    logic [RES_W-1:0] shaped_duty;
    logic [RES_W-1:0] cnt_next;
    logic             period_end;
    logic [RES_W-1:0] duty_act;

    dpwm_cmd_shaper #(
        .CMD_W(CMD_W), .RES_W(RES_W), .DUTY_MIN(DUTY_MIN), .DUTY_MAX(DUTY_MAX)
    ) u_shaper (
        .cmd  (duty_cmd),
        .duty (shaped_duty)
    );

    dpwm_period_timer #(.RES_W(RES_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_next   (cnt_next),
        .period_end (period_end)
    );

    dpwm_compare #(.RES_W(RES_W)) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_next   (cnt_next),
        .period_end (period_end),
        .load_en    (duty_cmd_valid),
        .load_duty  (shaped_duty),
        .pwm        (pwm_out),
        .strobe     (period_start),
        .act_duty   (duty_act)
    );
endmodule

// File: rtl/dpwm_clamped_chk.sv
module dpwm_clamped_chk #(
    parameter int RES_W    = dpwm_pkg::RES_W_DEF,
    parameter int DUTY_MAX = dpwm_pkg::DUTY_MAX_DEF
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pwm,
    input logic             stb,
    input logic [RES_W-1:0] act
);
    localparam int PERIOD = 2 ** RES_W;

    logic [RES_W:0] gap_q;   // clocks since the last strobe
    logic           seen_q;  // a strobe has occurred since reset
    logic [RES_W:0] hi_q;    // consecutive high clocks before this one

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
            hi_q   <= '0;
        end else begin
            if (stb) begin
                gap_q  <= '0;
                seen_q <= 1'b1;
            end else begin
                gap_q <= gap_q + 1'b1;
            end
            hi_q <= pwm ? hi_q + 1'b1 : '0;
        end
    end

    // R2: strobe lasts a single clock
    p_single_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stb |=> !stb);

    // R2: strobes are exactly one period apart
    p_period_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && seen_q) |-> (gap_q == (RES_W+1)'(PERIOD-1)));

    // R3: the output rises only at a period start
    p_rise_at_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm) |-> stb);

    // R5: no pulse is longer than the upper limit
    p_pulse_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pwm |-> (hi_q < (RES_W+1)'(DUTY_MAX)));

    // R5: the active duty never exceeds the upper limit
    p_act_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        act <= RES_W'(DUTY_MAX));

    // R7: the active duty changes only at a period start
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act) |-> stb);
endmodule

bind dpwm_clamped dpwm_clamped_chk #(
    .RES_W(RES_W), .DUTY_MAX(DUTY_MAX)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .pwm   (pwm_out),
    .stb   (period_start),
    .act   (duty_act)
);

// File: tb/dpwm_clamped_test.sv
`timescale 1ns/1ps
module dpwm_clamped_test;
    localparam int PERIOD = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] duty_cmd = '0;
    logic        duty_cmd_valid = 1'b0;
    logic        pwm_out;
    logic        period_start;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dpwm_clamped uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .duty_cmd       (duty_cmd),
        .duty_cmd_valid (duty_cmd_valid),
        .pwm_out        (pwm_out),
        .period_start   (period_start)
    );

    function automatic int expect_duty(input logic [15:0] c);
        int q;
        q = int'(c) / 64;
        if (q > 819) q = 819;
        return q;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Starts at the negedge of a strobe cycle; ends at the negedge of the next one.
    task automatic run_period(input int exp, input string req,
                              input int at1, input logic [15:0] v1,
                              input int at2, input logic [15:0] v2);
        int hi  = 0;
        int bad = 0;
        int stb_bad = 0;
        for (int i = 0; i < PERIOD; i++) begin
            if (pwm_out) hi++;
            if (pwm_out !== (i < exp)) bad++;
            if (period_start !== (i == 0)) stb_bad++;
            if (i == at1) begin
                duty_cmd = v1; duty_cmd_valid = 1'b1;
            end else if (i == at2) begin
                duty_cmd = v2; duty_cmd_valid = 1'b1;
            end else begin
                duty_cmd = 16'(i * 37 + 5); duty_cmd_valid = 1'b0;  // R9 junk
            end
            @(negedge clk);
        end
        duty_cmd_valid = 1'b0;
        chk(hi == exp, {req, " high clocks"}, hi, exp);
        chk(bad == 0, {req, " R3 pulse shape"}, bad, 0);
        chk(stb_bad == 0 && period_start === 1'b1, "R2 strobe spacing", stb_bad, 0);
    endtask

    task automatic t_reset_r1;
        int guard = 0;
        rst_n = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(pwm_out === 1'b0 && period_start === 1'b0, "R1 outputs in reset",
                int'(pwm_out) + 2 * int'(period_start), 0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        while (period_start !== 1'b1 && guard < 8) begin
            @(negedge clk);
            guard++;
        end
        chk(guard == 0, "R2 first strobe after reset", guard, 0);
        run_period(0, "R1 first period", -1, '0, -1, '0);
    endtask

    task automatic t_midperiod_r7;
        run_period(0, "R7 old duty kept", 100, 16'h8000, -1, '0);
        run_period(expect_duty(16'h8000), "R4 0x8000", -1, '0, -1, '0);
    endtask

    task automatic t_clamp_r5;
        run_period(512, "R7 before clamp", 5, 16'hCD00, -1, '0);
        run_period(expect_duty(16'hCD00), "R5 0xCD00", 300, 16'hFFFF, -1, '0);
        run_period(819, "R5 0xFFFF", -1, '0, -1, '0);
    endtask

    task automatic t_zero_r6;
        run_period(819, "R9 no valid keeps duty", 600, 16'h003F, -1, '0);
        run_period(0, "R6 zero duty", 2, 16'h0041, -1, '0);
    endtask

    task automatic t_quant_r4;
        run_period(1, "R4 0x0041", 700, 16'h12FF, -1, '0);
        run_period(75, "R4 0x12FF", -1, '0, -1, '0);
    endtask

    task automatic t_wrap_r8;
        run_period(75, "R8 before wrap load", PERIOD - 1, 16'h4000, -1, '0);
        run_period(256, "R8 wrap cycle load", -1, '0, -1, '0);
    endtask

    task automatic t_last_wins_r10;
        run_period(256, "R10 before", 10, 16'h1000, 900, 16'h2000);
        run_period(128, "R10 last command", -1, '0, -1, '0);
        run_period(128, "R9 junk ignored", -1, '0, -1, '0);
    endtask

    initial begin
        t_reset_r1();
        t_midperiod_r7();
        t_clamp_r5();
        t_zero_r6();
        t_quant_r4();
        t_wrap_r8();
        t_last_wins_r10();
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule